// File: doc/BRIEF.md
# Split-Transaction Tagged Bus Tracker

This block issues memory transactions onto a system bus whose address tenure and data tenure are granted separately. When the requester presents a transaction and the address bus is granted, the block labels the transaction with a 3-bit tag and drives the address phase at once. It can then issue more address phases while earlier transactions are still waiting for their data. Up to eight transactions can be outstanding, one for each tag value. When all eight tags are in use, new address phases are held off.

Data phases can arrive in any order and are matched by tag. A slow device therefore never blocks a faster one. For writes and read-modify-writes, the operand captured at issue is driven onto the data bus when the data bus is granted for that tag. Reads, read-modify-writes and invalidates complete through the tagged return channel. Each of these completions is passed back to the requester one cycle later. A data phase that names a tag in the wrong state raises a one-cycle error flag, and the block otherwise ignores it.

Top module: `split_txn_tracker`

## Requirements
- R1: After a synchronous active-low reset, no tag is in use, `cpl_valid` and `err_bad_tag` are 0, and `req_ready` equals `abus_gnt`.
- R2: An address phase (`a_valid`) carries the lowest-numbered tag not in use, along with `req_kind` and `req_addr` of that same cycle. Kind codes are 0 read, 1 write, 2 read-modify-write and 3 invalidate.
- R3: `abus_req` is high when `req_valid` is high and a tag is free. An address phase happens in the same cycle exactly when `req_valid`, `abus_gnt` and a free tag are all present, and `req_ready` equals `abus_gnt` AND a free tag exists.
- R4: While all eight tags are in use, `req_ready`, `abus_req` and `a_valid` stay 0.
- R5: New address phases can be issued while earlier transactions are still waiting for their data.
- R6: A return (`ret_valid`) whose tag holds a read or an invalidate produces, one cycle later, `cpl_valid` with that tag and kind. The completion carries `ret_data` for a read and zero for an invalidate, and the tag is released.
- R7: Transactions can complete in any order of tags, independent of the order in which they were issued.
- R8: A data grant (`dgnt_valid`) for a tag holding a write drives `wd_valid`, `wd_tag` and the write data captured at issue in the same cycle, and releases the tag.
- R9: A data grant for a read-modify-write tag whose operand has not yet gone out drives that operand and keeps the tag in use. A later return for that tag completes it with `ret_data`.
- R10: A return whose tag is free, holds a write, or holds a read-modify-write whose operand has not yet gone out raises `err_bad_tag` one cycle later. It produces no completion and leaves the tag state unchanged.
- R11: A data grant whose tag is free, holds a read or an invalidate, or holds a read-modify-write whose operand has already gone out raises `err_bad_tag` one cycle later. In that case `wd_valid` stays 0 and no state changes.
- R12: A tag released in a cycle can be reallocated from the next cycle onward, but not in the cycle in which it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Requester presents a transaction |
| req_kind | input | 2 | Transaction kind (0 read, 1 write, 2 rmw, 3 invalidate) |
| req_addr | input | ADDR_W | Transaction address |
| req_wdata | input | DATA_W | Write or rmw operand |
| req_ready | output | 1 | Transaction is accepted this cycle when valid |
| abus_req | output | 1 | Request for address tenure |
| abus_gnt | input | 1 | Address bus granted |
| a_valid | output | 1 | Address phase driven this cycle |
| a_kind | output | 2 | Address phase kind |
| a_addr | output | ADDR_W | Address phase address |
| a_tag | output | TAG_W | Address phase tag |
| dgnt_valid | input | 1 | Data bus granted for a tag |
| dgnt_tag | input | TAG_W | Tag of the data grant |
| wd_valid | output | 1 | Write data driven this cycle |
| wd_tag | output | TAG_W | Tag of driven data |
| wd_data | output | DATA_W | Driven write data |
| ret_valid | input | 1 | Tagged data return |
| ret_tag | input | TAG_W | Tag of the return |
| ret_data | input | DATA_W | Returned data |
| cpl_valid | output | 1 | Completion to the requester |
| cpl_kind | output | 2 | Kind of the completed transaction |
| cpl_tag | output | TAG_W | Tag of the completed transaction |
| cpl_data | output | DATA_W | Completion data |
| err_bad_tag | output | 1 | A data phase named a tag in the wrong state |

## Verification
The bench fills all eight tags and checks that the requester is held off. It then checks that a tag released in the same cycle as a new request is not handed out early; a design that reused the tag at once would drive a tag that is still being retired. Returns are issued in an order unrelated to issue order, including two releases in one cycle, one from a write grant and one from a return. A design that released only one of the two would leak a tag and stall later. The read-modify-write sequence is exercised out of order, with a return arriving before the operand grant and a repeated grant. Returns and grants to free tags are also sent. A design that freed or completed on any of these would show a spurious completion or write strobe, or a tag that vanishes.

// File: rtl/stt_pkg.sv
// Package: shared encodings for the split-transaction tracker.
// Assumes kind codes are fixed by the bus protocol (0..3).
package stt_pkg;
    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_RMW   = 2'd2,
        K_INVAL = 2'd3
    } txn_kind_e;
endpackage

// File: rtl/stt_tag_pool.sv
// Tag pool: a bitmap of in-use tags with a lowest-free picker.
// Assumes allocation targets only a free tag and release masks name only busy tags,
// so set and clear never hit the same bit in one cycle.
module stt_tag_pool #(
    parameter int TAG_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_en,
    input  logic [(1<<TAG_W)-1:0] free_mask,
    output logic [(1<<TAG_W)-1:0] busy,
    output logic                  any_free,
    output logic [TAG_W-1:0]      low_free
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0] busy_q;
    logic [NTAG-1:0] set_mask;

    // pick the lowest-numbered tag that is not in use
    always_comb begin
        low_free = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!busy_q[i]) low_free = TAG_W'(i);
        end
    end

    // free-tag availability and allocation mask
    always_comb begin
        any_free = ~&busy_q;
        set_mask = alloc_en ? (NTAG'(1) << low_free) : '0;
    end

    // bitmap update: releases and allocation take effect at the edge
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~free_mask) | set_mask;
    end

    assign busy = busy_q;
endmodule

// File: rtl/stt_slot_store.sv
// Per-tag slot store: kind, operand and operand-sent flag for each tag.
// Assumes a slot is written only at allocation; two independent read ports.
module stt_slot_store
    import stt_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  txn_kind_e         wr_kind,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sent_en,
    input  logic [TAG_W-1:0]  sent_tag,
    input  logic [TAG_W-1:0]  g_tag,
    output txn_kind_e         g_kind,
    output logic              g_sent,
    output logic [DATA_W-1:0] g_data,
    input  logic [TAG_W-1:0]  r_tag,
    output txn_kind_e         r_kind,
    output logic              r_sent
);
    localparam int NTAG = 1 << TAG_W;

    txn_kind_e         kind_q [NTAG];
    logic              sent_q [NTAG];
    logic [DATA_W-1:0] data_q [NTAG];

    for (genvar s = 0; s < NTAG; s++) begin : g_slot
        // control fields of slot s: set at allocation, sent flag set by operand grant
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_q[s] <= K_READ;
                sent_q[s] <= 1'b0;
            end else if (wr_en && wr_tag == TAG_W'(s)) begin
                kind_q[s] <= wr_kind;
                sent_q[s] <= 1'b0;
            end else if (sent_en && sent_tag == TAG_W'(s)) begin
                sent_q[s] <= 1'b1;
            end
        end

        // operand of slot s, captured at allocation
        always_ff @(posedge clk) begin
            if (wr_en && wr_tag == TAG_W'(s)) data_q[s] <= wr_data;
        end
    end

    // read ports for the grant side and the return side
    always_comb begin
        g_kind = kind_q[g_tag];
        g_sent = sent_q[g_tag];
        g_data = data_q[g_tag];
        r_kind = kind_q[r_tag];
        r_sent = sent_q[r_tag];
    end
endmodule

// File: rtl/stt_phase_ctl.sv
// Data-phase control: judges data grants and returns against tag state,
// drives write data, builds release masks, registers completions and errors.
// Assumes grant and return may name different tags in the same cycle.
module stt_phase_ctl
    import stt_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<TAG_W)-1:0] busy,
    input  logic                  dgnt_valid,
    input  logic [TAG_W-1:0]      dgnt_tag,
    input  txn_kind_e             g_kind,
    input  logic                  g_sent,
    input  logic [DATA_W-1:0]     g_data,
    input  logic                  ret_valid,
    input  logic [TAG_W-1:0]      ret_tag,
    input  logic [DATA_W-1:0]     ret_data,
    input  txn_kind_e             r_kind,
    input  logic                  r_sent,
    output logic                  wd_valid,
    output logic [TAG_W-1:0]      wd_tag,
    output logic [DATA_W-1:0]     wd_data,
    output logic [(1<<TAG_W)-1:0] free_mask,
    output logic                  sent_en,
    output logic                  cpl_valid,
    output txn_kind_e             cpl_kind,
    output logic [TAG_W-1:0]      cpl_tag,
    output logic [DATA_W-1:0]     cpl_data,
    output logic                  err
);
    localparam int NTAG = 1 << TAG_W;

    logic gnt_ok, ret_ok, gnt_bad, ret_bad;

    // legality of the grant and of the return against the slot state
    always_comb begin
        gnt_ok = dgnt_valid && busy[dgnt_tag] &&
                 (g_kind == K_WRITE || (g_kind == K_RMW && !g_sent));
        ret_ok = ret_valid && busy[ret_tag] &&
                 (r_kind == K_READ || r_kind == K_INVAL || (r_kind == K_RMW && r_sent));
        gnt_bad = dgnt_valid && !gnt_ok;
        ret_bad = ret_valid && !ret_ok;
    end

    // write data drive, release mask and operand-sent marking
    always_comb begin
        wd_valid  = gnt_ok;
        wd_tag    = dgnt_tag;
        wd_data   = g_data;
        sent_en   = gnt_ok && g_kind == K_RMW;
        free_mask = '0;
        if (gnt_ok && g_kind == K_WRITE) free_mask = free_mask | (NTAG'(1) << dgnt_tag);
        if (ret_ok)                      free_mask = free_mask | (NTAG'(1) << ret_tag);
    end

    // completion and error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_kind  <= K_READ;
            cpl_tag   <= '0;
            cpl_data  <= '0;
            err       <= 1'b0;
        end else begin
            cpl_valid <= ret_ok;
            err       <= gnt_bad || ret_bad;
            if (ret_ok) begin
                cpl_kind <= r_kind;
                cpl_tag  <= ret_tag;
                cpl_data <= (r_kind == K_INVAL) ? '0 : ret_data;
            end
        end
    end
endmodule

// File: rtl/split_txn_tracker.sv
// Top: split-transaction tagged bus tracker. Issues address phases with the
// lowest free tag, tracks up to 2**TAG_W outstanding transactions and retires
// them out of order by tag. Assumes the requester holds its request until
// req_ready and the address bus grant is sampled in the same cycle.
module split_txn_tracker
    import stt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              abus_req,
    input  logic              abus_gnt,
    output logic              a_valid,
    output logic [1:0]        a_kind,
    output logic [ADDR_W-1:0] a_addr,
    output logic [TAG_W-1:0]  a_tag,
    input  logic              dgnt_valid,
    input  logic [TAG_W-1:0]  dgnt_tag,
    output logic              wd_valid,
    output logic [TAG_W-1:0]  wd_tag,
    output logic [DATA_W-1:0] wd_data,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic [DATA_W-1:0] ret_data,
    output logic              cpl_valid,
    output logic [1:0]        cpl_kind,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [DATA_W-1:0] cpl_data,
    output logic              err_bad_tag
);
    localparam int NTAG = 1 << TAG_W;

    logic [NTAG-1:0]   busy, free_mask;
    logic              any_free, issue, sent_en;
    logic [TAG_W-1:0]  low_free;
    txn_kind_e         g_kind, r_kind, cpl_kind_e;
    logic              g_sent, r_sent;
    logic [DATA_W-1:0] g_data;

    // address tenure: request, accept and drive in the granted cycle
    always_comb begin
        abus_req  = req_valid && any_free;
        req_ready = abus_gnt && any_free;
        issue     = req_valid && req_ready;
        a_valid   = issue;
        a_kind    = req_kind;
        a_addr    = req_addr;
        a_tag     = low_free;
        cpl_kind  = cpl_kind_e;
    end

    stt_tag_pool #(.TAG_W(TAG_W)) i_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (issue),
        .free_mask (free_mask),
        .busy      (busy),
        .any_free  (any_free),
        .low_free  (low_free)
    );

    stt_slot_store #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (issue),
        .wr_tag   (low_free),
        .wr_kind  (txn_kind_e'(req_kind)),
        .wr_data  (req_wdata),
        .sent_en  (sent_en),
        .sent_tag (dgnt_tag),
        .g_tag    (dgnt_tag),
        .g_kind   (g_kind),
        .g_sent   (g_sent),
        .g_data   (g_data),
        .r_tag    (ret_tag),
        .r_kind   (r_kind),
        .r_sent   (r_sent)
    );

    stt_phase_ctl #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .dgnt_valid (dgnt_valid),
        .dgnt_tag   (dgnt_tag),
        .g_kind     (g_kind),
        .g_sent     (g_sent),
        .g_data     (g_data),
        .ret_valid  (ret_valid),
        .ret_tag    (ret_tag),
        .ret_data   (ret_data),
        .r_kind     (r_kind),
        .r_sent     (r_sent),
        .wd_valid   (wd_valid),
        .wd_tag     (wd_tag),
        .wd_data    (wd_data),
        .free_mask  (free_mask),
        .sent_en    (sent_en),
        .cpl_valid  (cpl_valid),
        .cpl_kind   (cpl_kind_e),
        .cpl_tag    (cpl_tag),
        .cpl_data   (cpl_data),
        .err        (err_bad_tag)
    );
endmodule

// File: rtl/stt_checks.sv
// Checker: temporal properties of the tracker, bound to the top module.
// Assumes the in-use bitmap of the tag pool is visible through the bind.
module stt_checks #(
    parameter int TAG_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  abus_gnt,
    input logic                  req_ready,
    input logic                  a_valid,
    input logic [TAG_W-1:0]      a_tag,
    input logic [(1<<TAG_W)-1:0] busy,
    input logic                  dgnt_valid,
    input logic [TAG_W-1:0]      dgnt_tag,
    input logic                  wd_valid,
    input logic [TAG_W-1:0]      wd_tag,
    input logic                  ret_valid,
    input logic [TAG_W-1:0]      ret_tag,
    input logic                  cpl_valid,
    input logic [TAG_W-1:0]      cpl_tag,
    input logic                  err_bad_tag
);
    a_r3_issue_needs_req_and_grant: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> (req_valid && abus_gnt));

    a_r4_full_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !req_ready);

    a_r12_issued_tag_busy: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |=> busy[$past(a_tag)]);

    a_r8_wd_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid |-> (dgnt_valid && wd_tag == dgnt_tag));

    a_r6_cpl_from_return: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> ($past(ret_valid) && cpl_tag == $past(ret_tag)));

    a_r6_cpl_tag_released: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !busy[cpl_tag]);

    a_r10_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_bad_tag |-> $past(ret_valid || dgnt_valid));
endmodule

bind split_txn_tracker stt_checks #(.TAG_W(TAG_W)) i_stt_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .abus_gnt    (abus_gnt),
    .req_ready   (req_ready),
    .a_valid     (a_valid),
    .a_tag       (a_tag),
    .busy        (busy),
    .dgnt_valid  (dgnt_valid),
    .dgnt_tag    (dgnt_tag),
    .wd_valid    (wd_valid),
    .wd_tag      (wd_tag),
    .ret_valid   (ret_valid),
    .ret_tag     (ret_tag),
    .cpl_valid   (cpl_valid),
    .cpl_tag     (cpl_tag),
    .err_bad_tag (err_bad_tag)
);

// File: tb/test_split_txn_tracker.sv
// Bench: behavioural per-tag reference model compared on every clock.
module test_split_txn_tracker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rv, gnt, gv, rtv;
    logic [1:0]  rk;
    logic [31:0] ra;
    logic [63:0] rwd, rd;
    logic [2:0]  gt, rt;

    logic        req_ready, abus_req, a_valid, wd_valid, cpl_valid, err_bad_tag;
    logic [1:0]  a_kind, cpl_kind;
    logic [31:0] a_addr;
    logic [2:0]  a_tag, wd_tag, cpl_tag;
    logic [63:0] wd_data, cpl_data;

    split_txn_tracker i_split_txn_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(rv), .req_kind(rk), .req_addr(ra), .req_wdata(rwd),
        .req_ready(req_ready), .abus_req(abus_req), .abus_gnt(gnt),
        .a_valid(a_valid), .a_kind(a_kind), .a_addr(a_addr), .a_tag(a_tag),
        .dgnt_valid(gv), .dgnt_tag(gt),
        .wd_valid(wd_valid), .wd_tag(wd_tag), .wd_data(wd_data),
        .ret_valid(rtv), .ret_tag(rt), .ret_data(rd),
        .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_tag(cpl_tag),
        .cpl_data(cpl_data), .err_bad_tag(err_bad_tag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state
    bit          m_busy [8];
    int          m_kind [8];
    logic [63:0] m_wdata [8];
    bit          m_sent [8];
    bit          e_cplv, e_err;
    int          e_cplk, e_cplt;
    logic [63:0] e_cpld;

    int    n_chk = 0, n_fail = 0;
    bit    done = 1'b0;
    string phase = "";

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic idle();
        rv = 0; rk = 0; ra = 0; rwd = 0; gnt = 1; gv = 0; gt = 0; rtv = 0; rt = 0; rd = 0;
    endtask

    // one clock: check outputs against the model, then advance the model
    task automatic tick();
        int  lf;
        bit  full, e_av, g_ok, r_ok;
        #1;
        lf = -1;
        for (int i = 0; i < 8; i++) if (!m_busy[i] && lf < 0) lf = i;
        full = (lf < 0);
        e_av = rv && gnt && !full;
        g_ok = gv && m_busy[gt] && (m_kind[gt] == 1 || (m_kind[gt] == 2 && !m_sent[gt]));
        r_ok = rtv && m_busy[rt] && (m_kind[rt] == 0 || m_kind[rt] == 3 ||
                                     (m_kind[rt] == 2 && m_sent[rt]));
        if (rst_n) begin
            chk("req_ready", req_ready, gnt && !full);
            chk("abus_req", abus_req, rv && !full);
            chk("a_valid", a_valid, e_av);
            if (e_av) begin
                chk("a_tag", a_tag, lf);
                chk("a_kind", a_kind, rk);
                chk("a_addr", a_addr, ra);
            end
            chk("wd_valid", wd_valid, g_ok);
            if (g_ok) begin
                chk("wd_tag", wd_tag, gt);
                chk("wd_data", wd_data, m_wdata[gt]);
            end
            chk("cpl_valid", cpl_valid, e_cplv);
            if (e_cplv) begin
                chk("cpl_tag", cpl_tag, e_cplt);
                chk("cpl_kind", cpl_kind, e_cplk);
                chk("cpl_data", cpl_data, e_cpld);
            end
            chk("err_bad_tag", err_bad_tag, e_err);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_busy[i] = 0; m_sent[i] = 0; m_kind[i] = 0; end
            e_cplv = 0; e_err = 0;
        end else begin
            e_cplv = r_ok;
            if (r_ok) begin
                e_cplt = rt; e_cplk = m_kind[rt];
                e_cpld = (m_kind[rt] == 3) ? 64'd0 : rd;
            end
            e_err = (rtv && !r_ok) || (gv && !g_ok);
            if (g_ok) begin
                if (m_kind[gt] == 1) m_busy[gt] = 0;
                else                 m_sent[gt] = 1;
            end
            if (r_ok) m_busy[rt] = 0;
            if (e_av) begin
                m_busy[lf] = 1; m_kind[lf] = rk; m_wdata[lf] = rwd; m_sent[lf] = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic req(logic [1:0] k, logic [31:0] a, logic [63:0] d);
        rv = 1; rk = k; ra = a; rwd = d;
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;

        phase = "R1 reset";
        tick();
        gnt = 0; tick(); idle();

        phase = "R2 R5 issue";
        req(0, 32'h1000, 64'h0); tick();
        req(1, 32'h2000, 64'hAAAA_0001); tick();
        req(2, 32'h3000, 64'hBBBB_0002); tick();
        req(3, 32'h4000, 64'h0); tick();
        idle();

        phase = "R3 no grant";
        req(0, 32'h5000, 64'h0); gnt = 0; tick(); idle(); tick();

        phase = "R6 R7 out-of-order return";
        rtv = 1; rt = 3; rd = 64'hDEAD; tick(); idle();
        rtv = 1; rt = 0; rd = 64'h1234_5678; tick(); idle(); tick();

        phase = "R8 write data phase";
        gv = 1; gt = 1; tick(); idle(); tick();

        phase = "R10 bad return";
        rtv = 1; rt = 2; rd = 64'h55; tick(); idle();
        rtv = 1; rt = 5; tick(); idle();
        rtv = 1; rt = 1; tick(); idle(); tick();

        phase = "R9 R11 rmw";
        gv = 1; gt = 2; tick(); idle();
        gv = 1; gt = 2; tick(); idle();
        rtv = 1; rt = 2; rd = 64'hC0FFEE; tick(); idle(); tick();

        phase = "R11 bad grant";
        gv = 1; gt = 6; tick(); idle();
        req(0, 32'h6000, 64'h0); tick(); idle();
        gv = 1; gt = 0; tick(); idle(); tick();

        phase = "R4 full";
        for (int i = 0; i < 8; i++) begin req(1, 32'h7000 + i, 64'h100 + i); tick(); end
        req(0, 32'h8000, 64'h0); tick();

        phase = "R12 free then reuse";
        req(0, 32'h9000, 64'h0); gv = 1; gt = 4; tick();
        gv = 0; tick(); idle(); tick();
        gv = 1; gt = 3; rtv = 1; rt = 4; rd = 64'h77; tick(); idle(); tick();

        phase = "R7 random";
        for (int c = 0; c < 3000; c++) begin
            idle();
            rv  = ($urandom % 10) < 6;
            rk  = 2'($urandom);
            ra  = $urandom;
            rwd = {$urandom, $urandom};
            gnt = ($urandom % 10) < 8;
            gv  = ($urandom % 10) < 3;
            gt  = 3'($urandom);
            rtv = ($urandom % 10) < 4;
            rt  = 3'($urandom);
            rd  = {$urandom, $urandom};
            tick();
        end
        idle(); tick(); tick();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule